// File: doc/BRIEF.md
# Supply Voltage Monitor Control Shell

This block is the digital wrapper around an analog supply-level comparator. Software reaches it through an 8-bit register bus. The registers select and gate the detector's sampling clock, turn the detector on, set a 4-bit threshold code for the comparator, and read back the latest comparison. A sticky low-supply flag and its mask produce an interrupt request.

The sampling rate comes from one of three source pulse trains, all in the same system clock domain. The low-speed oscillator pulse is used as is. The internal oscillator pulse is divided by 128. The high-speed oscillator pulse is divided by 512. The result is a single-cycle tick, and the block never switches clocks. On each tick the comparator output is sampled, but only while both the detector is enabled and the clock gate is open. A low sample sets the flag, and the flag holds until software clears it.

Top module: `supply_monitor_ctl`

## Requirements
- R1: After reset the clock register (0x5066) reads 0x04, which is source code 1 with the gate off. The enable (0x5100), level (0x5101), result (0x5102), mask (0x5103) and flag (0x5104) registers all read 0x00, and `irq` is 0.
- R2: In the clock register, bits 3:2 hold the source code and bit 0 holds the gate. Bits 7:4 and bit 1 always read 0, so writing 0xFF reads back 0x0D.
- R3: With source code 1 and the gate open, every `lf_pulse` is a sampling tick.
- R4: With source code 0, one tick occurs on every 128th `io_pulse`. Counting starts from reset.
- R5: With source code 2, one tick occurs on every 512th `hs_pulse`. Counting starts from reset.
- R6: Source code 3 produces no ticks.
- R7: No sample is taken while the gate (clock bit 0) or the detector enable (enable bit 0) is 0.
- R8: On a sampling tick, result bit 0 takes the value of `cmp_low`, where 1 means the supply is below the threshold. The new value is readable in the following cycle.
- R9: A sample with `cmp_low`=1 sets flag bit 0. The flag stays set through later high-supply samples.
- R10: Writing 1 to flag bit 0 clears the flag, and writing 0 there has no effect. If a setting sample and a clear fall in the same cycle, the flag stays set.
- R11: `irq` is 1 exactly while flag bit 0 and mask bit 0 are both 1.
- R12: Bits 3:0 of the level register drive `cmp_level`, and bits 7:4 of that register read 0.
- R13: Writes to the result register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| lf_pulse | input | 1 | Low-speed oscillator enable pulse |
| io_pulse | input | 1 | Internal oscillator enable pulse |
| hs_pulse | input | 1 | High-speed oscillator enable pulse |
| cmp_low | input | 1 | Comparator output, 1 when the supply is below the threshold |
| cmp_level | output | 4 | Threshold code driven to the comparator |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect on the clock edge that captures it. Its readback, `cmp_level` and `irq` change in the cycle after that edge. A tick is formed combinationally in the cycle of the source pulse, so a sample lands in the result and flag registers at that cycle's edge and `irq` follows in the next cycle. The bench updates its behavioural model at every rising edge from the inputs held across that edge. It compares `irq` and `cmp_level` one nanosecond after the edge and takes register reads between edges. It also uses fixed expectations at the 127th/128th and 511th/512th divider pulses.

// File: rtl/svm_pkg.sv
package svm_pkg;
  typedef enum logic [1:0] {
    SRC_IO_DIV = 2'd0,
    SRC_LF     = 2'd1,
    SRC_HS_DIV = 2'd2,
    SRC_OFF    = 2'd3
  } src_sel_e;

  localparam logic [15:0] A_CLOCK  = 16'h5066;
  localparam logic [15:0] A_ENABLE = 16'h5100;
  localparam logic [15:0] A_LEVEL  = 16'h5101;
  localparam logic [15:0] A_RESULT = 16'h5102;
  localparam logic [15:0] A_MASK   = 16'h5103;
  localparam logic [15:0] A_FLAG   = 16'h5104;
endpackage

// File: rtl/svm_pulse_div.sv
module svm_pulse_div #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic pulse_out
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last   = (cnt_q == LAST);
  assign pulse_out = pulse_in && at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (pulse_in) cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_out_needs_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> pulse_in);
endmodule

// File: rtl/svm_tick_gen.sv
module svm_tick_gen
  import svm_pkg::*;
#(
  parameter int IO_DIV = 128,
  parameter int HS_DIV = 512
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lf_pulse,
  input  logic     io_pulse,
  input  logic     hs_pulse,
  input  src_sel_e src,
  input  logic     gate,
  output logic     tick
);
  localparam int NDIV = 2;
  logic [NDIV-1:0] raw_in, div_out;
  assign raw_in = {hs_pulse, io_pulse};

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    localparam int D = (g == 0) ? IO_DIV : HS_DIV;
    svm_pulse_div #(.DIV(D)) u_div (
      .clk(clk), .rst_n(rst_n), .pulse_in(raw_in[g]), .pulse_out(div_out[g])
    );
  end

  logic sel_tick;
  always_comb begin
    case (src)
      SRC_IO_DIV: sel_tick = div_out[0];
      SRC_LF:     sel_tick = lf_pulse;
      SRC_HS_DIV: sel_tick = div_out[1];
      default:    sel_tick = 1'b0;
    endcase
  end

  assign tick = gate && sel_tick;

  p_hs_tick_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && src == SRC_HS_DIV) |-> hs_pulse);
endmodule

// File: rtl/svm_detect.sv
module svm_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic det_en,
  input  logic cmp_low,
  input  logic flag_clr,
  output logic result_q,
  output logic flag_q
);
  logic sample, set_flag;
  logic result_d, flag_d;

  assign sample   = tick && det_en;
  assign set_flag = sample && cmp_low;

  always_comb begin
    result_d = result_q;
    if (sample) result_d = cmp_low;
    flag_d = flag_q;
    if (set_flag)      flag_d = 1'b1;
    else if (flag_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      flag_q   <= flag_d;
    end
  end

  p_hold_without_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && det_en) |=> $stable(result_q));
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && det_en && cmp_low) |=> flag_q);
endmodule

// File: rtl/supply_monitor_ctl.sv
module supply_monitor_ctl
  import svm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 4,
  parameter int IO_DIV = 128,
  parameter int HS_DIV = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              lf_pulse,
  input  logic              io_pulse,
  input  logic              hs_pulse,
  input  logic              cmp_low,
  output logic [LVL_W-1:0]  cmp_level,
  output logic              irq
);
  localparam int PAD_LVL = DATA_W - LVL_W;

  // reset: asserted at once, released after two edges
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // register state
  src_sel_e         src_q, src_d;
  logic             gate_q, gate_d;
  logic             en_q, en_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             ie_q, ie_d;
  logic             flag_clr;

  logic wr_clk, wr_en, wr_lvl, wr_msk, wr_flg;
  assign wr_clk = bus_wr && (bus_addr == ADDR_W'(A_CLOCK));
  assign wr_en  = bus_wr && (bus_addr == ADDR_W'(A_ENABLE));
  assign wr_lvl = bus_wr && (bus_addr == ADDR_W'(A_LEVEL));
  assign wr_msk = bus_wr && (bus_addr == ADDR_W'(A_MASK));
  assign wr_flg = bus_wr && (bus_addr == ADDR_W'(A_FLAG));
  assign flag_clr = wr_flg && bus_wdata[0];

  always_comb begin
    src_d  = src_q;
    gate_d = gate_q;
    en_d   = en_q;
    lvl_d  = lvl_q;
    ie_d   = ie_q;
    if (wr_clk) begin
      src_d  = src_sel_e'(bus_wdata[3:2]);
      gate_d = bus_wdata[0];
    end
    if (wr_en)  en_d  = bus_wdata[0];
    if (wr_lvl) lvl_d = bus_wdata[LVL_W-1:0];
    if (wr_msk) ie_d  = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      src_q  <= SRC_LF;
      gate_q <= 1'b0;
      en_q   <= 1'b0;
      lvl_q  <= '0;
      ie_q   <= 1'b0;
    end else begin
      src_q  <= src_d;
      gate_q <= gate_d;
      en_q   <= en_d;
      lvl_q  <= lvl_d;
      ie_q   <= ie_d;
    end
  end

  logic tick, result_q, flag_q;

  svm_tick_gen #(.IO_DIV(IO_DIV), .HS_DIV(HS_DIV)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .lf_pulse(lf_pulse), .io_pulse(io_pulse),
    .hs_pulse(hs_pulse), .src(src_q), .gate(gate_q), .tick(tick)
  );

  svm_detect u_det (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .det_en(en_q), .cmp_low(cmp_low),
    .flag_clr(flag_clr), .result_q(result_q), .flag_q(flag_q)
  );

  assign cmp_level = lvl_q;
  assign irq       = flag_q && ie_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CLOCK):  bus_rdata = DATA_W'({4'b0000, src_q, 1'b0, gate_q});
      ADDR_W'(A_ENABLE): bus_rdata = DATA_W'(en_q);
      ADDR_W'(A_LEVEL):  bus_rdata = {{PAD_LVL{1'b0}}, lvl_q};
      ADDR_W'(A_RESULT): bus_rdata = DATA_W'(result_q);
      ADDR_W'(A_MASK):   bus_rdata = DATA_W'(ie_q);
      ADDR_W'(A_FLAG):   bus_rdata = DATA_W'(flag_q);
      default:           bus_rdata = '0;
    endcase
  end

  p_reserved_code_silent_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (src_q == SRC_OFF) |-> !tick);
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    !ie_q |-> !irq);
  p_gate_closed_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !gate_q |-> !tick);
  p_lf_direct_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (src_q == SRC_LF && gate_q && lf_pulse) |-> tick);
endmodule

// File: tb/supply_monitor_ctl_bench.sv
`timescale 1ns/1ps
module supply_monitor_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h0;
  logic [7:0]  bus_rdata;
  logic        lf_pulse = 1'b0, io_pulse = 1'b0, hs_pulse = 1'b0, cmp_low = 1'b0;
  logic [3:0]  cmp_level;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  supply_monitor_ctl u_supply_monitor_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lf_pulse(lf_pulse),
    .io_pulse(io_pulse), .hs_pulse(hs_pulse), .cmp_low(cmp_low),
    .cmp_level(cmp_level), .irq(irq)
  );

  // behavioural model
  int m_src = 1, m_gate = 0, m_en = 0, m_lvl = 0, m_res = 0, m_flag = 0, m_ie = 0;
  int m_io = 0, m_hs = 0;

  function automatic int model_read(input int a);
    case (a)
      'h5066: return (m_src << 2) | m_gate;
      'h5100: return m_en;
      'h5101: return m_lvl;
      'h5102: return m_res;
      'h5103: return m_ie;
      'h5104: return m_flag;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    int tk, samp, setf, clr, a;
    @(posedge clk);
    tk = 0;
    if (m_src == 1) tk = lf_pulse;
    else if (m_src == 0) tk = (io_pulse && m_io == 127) ? 1 : 0;
    else if (m_src == 2) tk = (hs_pulse && m_hs == 511) ? 1 : 0;
    if (io_pulse) m_io = (m_io + 1) % 128;
    if (hs_pulse) m_hs = (m_hs + 1) % 512;
    tk   = tk & m_gate;
    samp = tk & m_en;
    setf = samp & int'(cmp_low);
    if (samp != 0) m_res = cmp_low;
    a   = int'(bus_addr);
    clr = (bus_wr && a == 'h5104 && bus_wdata[0]) ? 1 : 0;
    if (bus_wr) begin
      if (a == 'h5066) begin m_src = int'(bus_wdata[3:2]); m_gate = bus_wdata[0]; end
      if (a == 'h5100) m_en  = bus_wdata[0];
      if (a == 'h5101) m_lvl = int'(bus_wdata[3:0]);
      if (a == 'h5103) m_ie  = bus_wdata[0];
    end
    if (setf != 0) m_flag = 1;
    else if (clr != 0) m_flag = 0;
    #1;
    chk("R11 irq", int'(irq), m_flag & m_ie);
    chk("R12 level", int'(cmp_level), m_lvl);
  endtask

  task automatic wr(input int a, input int d);
    bus_addr = 16'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    bus_addr = 16'(a);
    #0.5;
    chk(tag, int'(bus_rdata), exp);
    chk({tag, " model"}, int'(bus_rdata), model_read(a));
  endtask

  task automatic pulses(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      lf_pulse = (which == 0); io_pulse = (which == 1); hs_pulse = (which == 2);
      step();
    end
    lf_pulse = 0; io_pulse = 0; hs_pulse = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    rd("R1 clock", 'h5066, 'h04);
    rd("R1 enable", 'h5100, 0);
    rd("R1 level", 'h5101, 0);
    rd("R1 result", 'h5102, 0);
    rd("R1 mask", 'h5103, 0);
    rd("R1 flag", 'h5104, 0);
    chk("R1 irq", int'(irq), 0);

    // R2 reserved bits, R6 reserved code
    wr('h5066, 'hFF);
    rd("R2 clock readback", 'h5066, 'h0D);
    wr('h5100, 1);
    cmp_low = 1;
    pulses(0, 10);
    rd("R6 no sample", 'h5102, 0);
    rd("R6 no flag", 'h5104, 0);

    // R3 direct source, R8, R9, R11
    wr('h5066, 'h05);
    pulses(0, 1);
    rd("R3 R8 result low", 'h5102, 1);
    rd("R9 flag set", 'h5104, 1);
    chk("R11 irq masked", int'(irq), 0);
    wr('h5103, 1);
    chk("R11 irq on", int'(irq), 1);
    cmp_low = 0;
    pulses(0, 1);
    rd("R8 result high", 'h5102, 0);
    rd("R9 flag sticky", 'h5104, 1);
    // R10 clears
    wr('h5104, 0);
    rd("R10 write zero", 'h5104, 1);
    wr('h5104, 1);
    rd("R10 cleared", 'h5104, 0);
    chk("R11 irq off", int'(irq), 0);

    // R7 gating
    cmp_low = 1;
    wr('h5100, 0);
    pulses(0, 3);
    rd("R7 detector off", 'h5102, 0);
    wr('h5100, 1);
    wr('h5066, 'h04);
    pulses(0, 3);
    rd("R7 gate closed", 'h5102, 0);
    rd("R7 no flag", 'h5104, 0);

    // R4 divide by 128
    wr('h5066, 'h01);
    pulses(1, 127);
    rd("R4 before 128th", 'h5102, 0);
    pulses(1, 1);
    rd("R4 at 128th", 'h5102, 1);
    cmp_low = 0;
    pulses(1, 128);
    rd("R4 next period", 'h5102, 0);

    // R5 divide by 512
    wr('h5104, 1);
    wr('h5066, 'h09);
    cmp_low = 1;
    pulses(2, 511);
    rd("R5 before 512th", 'h5102, 0);
    pulses(2, 1);
    rd("R5 at 512th", 'h5102, 1);

    // R10 set wins over clear
    wr('h5066, 'h05);
    wr('h5104, 1);
    rd("R10 clear before race", 'h5104, 0);
    bus_addr = 16'h5104; bus_wdata = 8'h01; bus_wr = 1'b1; lf_pulse = 1'b1;
    step();
    bus_wr = 1'b0; lf_pulse = 1'b0;
    rd("R10 set wins", 'h5104, 1);

    // R12 level, R13 result read-only
    wr('h5101, 'hAB);
    rd("R12 level readback", 'h5101, 'h0B);
    chk("R12 level pins", int'(cmp_level), 'hB);
    wr('h5102, 0);
    rd("R13 result unchanged", 'h5102, 1);
    pulses(3, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule